// File: doc/BRIEF.md
# Shared Data Memory Lockout Arbiter

This block holds one joint controller's byte-wide data memory and shares it between two masters: the local 8-bit servo processor and a host that reaches many joints over a common byte bus. The host first picks a joint by number. Only the joint whose number matches accepts the transfers that follow. Each transfer is a single byte read or write, and the host sees it through a busy/ready handshake.

The local processor never asks for permission. Each of its shared-memory accesses latches the lowest address bit into a lock flag. An even address closes the gate to the host and an odd address opens it again. Software therefore stores a 16-bit value as its even byte followed by its odd byte, and the host can never observe half of an update.

A pending host transfer is started only in a cycle where three conditions hold: the gate is open, the processor is fetching an instruction, and the processor makes no data access. In that one cycle the address, data and control selectors switch to the host. In the next cycle they belong to the processor again.

Top module: `shmem_lock_arbiter`

## Requirements
- R1: After reset, `hs_busy` and `hs_ready` are 0 and the lock flag is clear. A host transfer is therefore granted at the first fetch cycle, with no prior local access needed.
- R2: A local access (`lp_acc`=1) with `lp_addr[0]`=0 closes the gate. From then on a pending host transfer stays pending through any number of fetch cycles.
- R3: A local access with `lp_addr[0]`=1 opens the gate. After that, a pending host transfer is granted at the next qualifying fetch cycle.
- R4: A host transfer is granted only in a cycle where `lp_fetch`=1. Without fetch cycles, `hs_busy` stays 1.
- R5: A grant in cycle t makes `hs_ready` 1 in cycle t+1 for exactly one cycle. `hs_busy` drops to 0 in that same cycle t+1.
- R6: A granted host write (`hs_we`=1) stores `hs_wdata` at `hs_addr`, and later local reads of that address return it.
- R7: A granted host read returns the byte at `hs_addr` on `hs_rdata` while `hs_ready` is 1.
- R8: `hs_sel_en` with `hs_sel_id` equal to JOINT_ID selects this joint, and any other id deselects it. An `hs_req` while the joint is deselected is ignored: `hs_busy` stays 0, `hs_ready` stays 0, and memory is unchanged.
- R9: An `hs_req` arriving while `hs_busy`=1 is ignored. Only the first transfer completes, and its address and data are the ones used.
- R10: A local access stores `lp_wdata` on a write, or puts the byte at `lp_addr` on `lp_rdata` in the next cycle on a read.
- R11: No grant occurs in a cycle where `lp_acc`=1, even with `lp_fetch`=1. The cycle after a grant, a local access proceeds normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| lp_acc | input | 1 | Local processor shared-memory access this cycle |
| lp_we | input | 1 | Local access is a write |
| lp_addr | input | ADDR_W | Local byte address |
| lp_wdata | input | DATA_W | Local write data |
| lp_fetch | input | 1 | Local processor is in an instruction-fetch cycle |
| lp_rdata | output | DATA_W | Read data, valid the cycle after a local read |
| hs_sel_en | input | 1 | Host joint-select strobe |
| hs_sel_id | input | ID_W | Joint number being selected |
| hs_req | input | 1 | Host transfer request strobe |
| hs_we | input | 1 | Host transfer is a write |
| hs_addr | input | ADDR_W | Host byte address |
| hs_wdata | input | DATA_W | Host write data |
| hs_busy | output | 1 | A host transfer is pending |
| hs_ready | output | 1 | One-cycle pulse: write committed or read data valid |
| hs_rdata | output | DATA_W | Host read data, valid while hs_ready is 1 |

## Verification
A lock flag stuck at the wrong value shows at the ports within one fetch cycle: either `hs_busy` stays high when it should fall, or `hs_ready` pulses while the gate should be closed. A wrong selector choice shows the next time the corrupted location is read back from either side. The bench compares busy, ready and read data against a behavioural model on every clock, so a divergence is reported in the cycle it first appears.

// File: rtl/shmem_arb_pkg.sv
package shmem_arb_pkg;

    // Which master drives the memory selectors this cycle
    typedef enum logic {
        OWN_LOCAL = 1'b0,
        OWN_HOST  = 1'b1
    } owner_e;

endpackage

// File: rtl/lock_tracker.sv
module lock_tracker (
    input  logic clk,
    input  logic rst_n,
    input  logic acc,
    input  logic addr_lsb,
    output logic locked
);

    typedef struct packed {
        logic lock;
    } lk_state_t;

    lk_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (acc) begin
            st_d.lock = ~addr_lsb;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign locked = st_q.lock;

    // R3
    odd_opens_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && addr_lsb) |=> !locked);

endmodule

// File: rtl/host_port.sv
module host_port #(
    parameter int ADDR_W   = 10,
    parameter int DATA_W   = 8,
    parameter int ID_W     = 3,
    parameter int JOINT_ID = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_en,
    input  logic [ID_W-1:0]   sel_id,
    input  logic              req,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              grant,
    output logic              busy,
    output logic              ready,
    output logic              p_we,
    output logic [ADDR_W-1:0] p_addr,
    output logic [DATA_W-1:0] p_wdata
);

    localparam logic [ID_W-1:0] MY_ID = ID_W'(JOINT_ID);

    typedef struct packed {
        logic              sel;
        logic              pend;
        logic              we;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic              ready;
    } hp_state_t;

    hp_state_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.ready = grant;
        if (grant) begin
            st_d.pend = 1'b0;
        end
        if (req && st_q.sel && !st_q.pend) begin
            st_d.pend  = 1'b1;
            st_d.we    = we;
            st_d.addr  = addr;
            st_d.wdata = wdata;
        end
        if (sel_en) begin
            st_d.sel = (sel_id == MY_ID);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy    = st_q.pend;
    assign ready   = st_q.ready;
    assign p_we    = st_q.we;
    assign p_addr  = st_q.addr;
    assign p_wdata = st_q.wdata;

    // R5
    ready_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> !ready);

    // R9
    held_request_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !grant) |=> (busy && p_addr == $past(p_addr) && p_wdata == $past(p_wdata)));

    // R8
    selected_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(st_q.sel));

endmodule

// File: rtl/sram_core.sv
module sram_core
    import shmem_arb_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  owner_e            owner,
    input  logic              h_we,
    input  logic [ADDR_W-1:0] h_addr,
    input  logic [DATA_W-1:0] h_wdata,
    input  logic              l_acc,
    input  logic              l_we,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic [DATA_W-1:0] l_wdata,
    output logic [DATA_W-1:0] rdata
);

    localparam int DEPTH = 1 << ADDR_W;

    typedef struct packed {
        logic [DATA_W-1:0] rd;
    } sr_state_t;

    sr_state_t         st_d, st_q;
    logic [DATA_W-1:0] mem_q [DEPTH];

    logic              en_mx;
    logic              we_mx;
    logic [ADDR_W-1:0] addr_mx;
    logic [DATA_W-1:0] wd_mx;

    // 2-to-1 selectors on address, data and control
    always_comb begin
        if (owner == OWN_HOST) begin
            en_mx   = 1'b1;
            we_mx   = h_we;
            addr_mx = h_addr;
            wd_mx   = h_wdata;
        end else begin
            en_mx   = l_acc;
            we_mx   = l_acc & l_we;
            addr_mx = l_addr;
            wd_mx   = l_wdata;
        end
        st_d = st_q;
        if (en_mx && !we_mx) begin
            st_d.rd = mem_q[addr_mx];
        end
    end

    always_ff @(posedge clk) begin
        if (en_mx && we_mx) begin
            mem_q[addr_mx] <= wd_mx;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rdata = st_q.rd;

    // R11
    no_collision_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (owner == OWN_HOST) |-> !l_acc);

endmodule

// File: rtl/shmem_lock_arbiter.sv
module shmem_lock_arbiter
    import shmem_arb_pkg::*;
#(
    parameter int ADDR_W   = 10,
    parameter int DATA_W   = 8,
    parameter int ID_W     = 3,
    parameter int JOINT_ID = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lp_acc,
    input  logic              lp_we,
    input  logic [ADDR_W-1:0] lp_addr,
    input  logic [DATA_W-1:0] lp_wdata,
    input  logic              lp_fetch,
    output logic [DATA_W-1:0] lp_rdata,
    input  logic              hs_sel_en,
    input  logic [ID_W-1:0]   hs_sel_id,
    input  logic              hs_req,
    input  logic              hs_we,
    input  logic [ADDR_W-1:0] hs_addr,
    input  logic [DATA_W-1:0] hs_wdata,
    output logic              hs_busy,
    output logic              hs_ready,
    output logic [DATA_W-1:0] hs_rdata
);

    logic              locked;
    logic              grant;
    owner_e            owner;
    logic              p_we;
    logic [ADDR_W-1:0] p_addr;
    logic [DATA_W-1:0] p_wdata;
    logic [DATA_W-1:0] rd_bus;

    lock_tracker u_lock (
        .clk      (clk),
        .rst_n    (rst_n),
        .acc      (lp_acc),
        .addr_lsb (lp_addr[0]),
        .locked   (locked)
    );

    host_port #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .ID_W     (ID_W),
        .JOINT_ID (JOINT_ID)
    ) u_host (
        .clk     (clk),
        .rst_n   (rst_n),
        .sel_en  (hs_sel_en),
        .sel_id  (hs_sel_id),
        .req     (hs_req),
        .we      (hs_we),
        .addr    (hs_addr),
        .wdata   (hs_wdata),
        .grant   (grant),
        .busy    (hs_busy),
        .ready   (hs_ready),
        .p_we    (p_we),
        .p_addr  (p_addr),
        .p_wdata (p_wdata)
    );

    // Host slot: gate open, fetch cycle, and no local data access
    always_comb begin
        grant = hs_busy && !locked && lp_fetch && !lp_acc;
        owner = grant ? OWN_HOST : OWN_LOCAL;
    end

    sram_core #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_mem (
        .clk     (clk),
        .rst_n   (rst_n),
        .owner   (owner),
        .h_we    (p_we),
        .h_addr  (p_addr),
        .h_wdata (p_wdata),
        .l_acc   (lp_acc),
        .l_we    (lp_we),
        .l_addr  (lp_addr),
        .l_wdata (lp_wdata),
        .rdata   (rd_bus)
    );

    assign lp_rdata = rd_bus;
    assign hs_rdata = rd_bus;

    // R4
    fetch_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hs_ready |-> ($past(lp_fetch) && !$past(lp_acc)));

    // R2
    lock_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hs_ready |-> !$past(locked));

    // R5
    busy_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hs_busy) |-> hs_ready);

endmodule

// File: tb/shmem_lock_arbiter_test.sv
module shmem_lock_arbiter_test;

    localparam int AW  = 10;
    localparam int DW  = 8;
    localparam int IW  = 3;
    localparam int JID = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          lp_acc = 1'b0, lp_we = 1'b0, lp_fetch = 1'b0;
    logic [AW-1:0] lp_addr = '0;
    logic [DW-1:0] lp_wdata = '0;
    logic [DW-1:0] lp_rdata;
    logic          hs_sel_en = 1'b0, hs_req = 1'b0, hs_we = 1'b0;
    logic [IW-1:0] hs_sel_id = '0;
    logic [AW-1:0] hs_addr = '0;
    logic [DW-1:0] hs_wdata = '0;
    logic          hs_busy, hs_ready;
    logic [DW-1:0] hs_rdata;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    shmem_lock_arbiter #(.ADDR_W(AW), .DATA_W(DW), .ID_W(IW), .JOINT_ID(JID)) uut (
        .clk(clk), .rst_n(rst_n),
        .lp_acc(lp_acc), .lp_we(lp_we), .lp_addr(lp_addr), .lp_wdata(lp_wdata),
        .lp_fetch(lp_fetch), .lp_rdata(lp_rdata),
        .hs_sel_en(hs_sel_en), .hs_sel_id(hs_sel_id), .hs_req(hs_req), .hs_we(hs_we),
        .hs_addr(hs_addr), .hs_wdata(hs_wdata),
        .hs_busy(hs_busy), .hs_ready(hs_ready), .hs_rdata(hs_rdata)
    );

    // Behavioural reference model
    logic [DW-1:0] m_mem [1024];
    bit            m_sel, m_lock, m_pend, m_pwe, m_ready;
    int            m_paddr, m_pdata, m_rd;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_sel = 0; m_lock = 0; m_pend = 0; m_ready = 0; m_rd = 0;
        end else begin
            bit go, take;
            go   = m_pend && !m_lock && lp_fetch && !lp_acc;
            take = hs_req && m_sel && !m_pend;
            m_ready = go;
            if (go) begin
                if (m_pwe) m_mem[m_paddr] = m_pdata[DW-1:0];
                else       m_rd = int'(m_mem[m_paddr]);
                m_pend = 0;
            end else if (lp_acc) begin
                if (lp_we) m_mem[lp_addr] = lp_wdata;
                else       m_rd = int'(m_mem[lp_addr]);
            end
            if (lp_acc) m_lock = !lp_addr[0];
            if (take) begin
                m_pend = 1; m_pwe = hs_we; m_paddr = int'(hs_addr); m_pdata = int'(hs_wdata);
            end
            if (hs_sel_en) m_sel = (int'(hs_sel_id) == JID);
        end
    end

    task automatic chk(string tag, int got, int exp);
        checks++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s got=%0h exp=%0h t=%0t", tag, got, exp, $time);
        end
    endtask

    // Per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n) begin
            chk("R9 busy", int'(hs_busy), int'(m_pend));
            chk("R5 ready", int'(hs_ready), int'(m_ready));
            chk("R7 rdata", int'(lp_rdata), m_rd);
        end
    end

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic lacc(bit we, int a, int d);
        lp_acc = 1; lp_we = we; lp_addr = AW'(a); lp_wdata = DW'(d); lp_fetch = 0;
        tick();
        lp_acc = 0; lp_we = 0;
    endtask

    task automatic hreq(bit we, int a, int d);
        hs_req = 1; hs_we = we; hs_addr = AW'(a); hs_wdata = DW'(d);
        tick();
        hs_req = 0; hs_we = 0;
    endtask

    task automatic hsel(int id);
        hs_sel_en = 1; hs_sel_id = IW'(id);
        tick();
        hs_sel_en = 0;
    endtask

    task automatic fetch1();
        lp_fetch = 1;
        tick();
        lp_fetch = 0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) tick();
        rst_n = 1;
        tick();
        chk("R1 busy", int'(hs_busy), 0);
        chk("R1 ready", int'(hs_ready), 0);

        hsel(JID);
        // Lock clear from reset: first fetch grants
        hreq(1, 'h50, 'hC3);
        chk("R4 busy", int'(hs_busy), 1);
        fetch1();
        chk("R1 ready", int'(hs_ready), 1);
        chk("R5 busy", int'(hs_busy), 0);
        tick();
        chk("R5 ready", int'(hs_ready), 0);
        lacc(0, 'h50, 0);
        chk("R6 rd", int'(lp_rdata), 'hC3);
        lacc(1, 'h51, 'h00);

        // Local 16-bit pair then readback
        lacc(1, 'h10, 'hA5);
        lacc(1, 'h11, 'h5A);
        lacc(0, 'h10, 0);
        chk("R10 rd", int'(lp_rdata), 'hA5);
        lacc(1, 'h11, 'h5A);

        // Host read waits for fetch
        hreq(0, 'h10, 0);
        for (int i = 0; i < 3; i++) begin
            tick();
            chk("R4 busy", int'(hs_busy), 1);
        end
        fetch1();
        chk("R7 ready", int'(hs_ready), 1);
        chk("R7 data", int'(hs_rdata), 'hA5);
        tick();

        // Even access closes the gate, odd access opens it
        lacc(0, 'h10, 0);
        hreq(1, 'h21, 'h77);
        lp_fetch = 1;
        for (int i = 0; i < 3; i++) begin
            tick();
            chk("R2 busy", int'(hs_busy), 1);
        end
        lp_fetch = 0;
        lacc(0, 'h11, 0);
        chk("R2 busy", int'(hs_busy), 1);
        fetch1();
        chk("R3 ready", int'(hs_ready), 1);
        lacc(0, 'h21, 0);
        chk("R6 rd", int'(lp_rdata), 'h77);

        // No grant while the processor accesses data
        hreq(1, 'h30, 'h11);
        lp_fetch = 1; lp_acc = 1; lp_we = 1; lp_addr = AW'('h31); lp_wdata = 8'hEE;
        tick();
        lp_acc = 0; lp_we = 0;
        chk("R11 busy", int'(hs_busy), 1);
        chk("R11 ready", int'(hs_ready), 0);
        tick();
        lp_fetch = 0;
        chk("R11 ready", int'(hs_ready), 1);
        lacc(0, 'h30, 0);
        chk("R11 rd", int'(lp_rdata), 'h11);
        lacc(1, 'h33, 0);

        // Second request while busy is dropped
        hreq(1, 'h30, 'h44);
        hreq(1, 'h31, 'h99);
        fetch1();
        chk("R9 ready", int'(hs_ready), 1);
        tick();
        chk("R9 ready", int'(hs_ready), 0);
        chk("R9 busy", int'(hs_busy), 0);
        lacc(0, 'h31, 0);
        chk("R9 rd", int'(lp_rdata), 'hEE);
        lacc(0, 'h30, 0);
        chk("R6 rd", int'(lp_rdata), 'h44);
        lacc(1, 'h33, 0);

        // Deselected joint ignores host
        hsel(2);
        hreq(1, 'h30, 'h55);
        chk("R8 busy", int'(hs_busy), 0);
        fetch1();
        chk("R8 ready", int'(hs_ready), 0);
        lacc(0, 'h30, 0);
        chk("R8 rd", int'(lp_rdata), 'h44);
        lacc(1, 'h33, 0);
        hsel(JID);
        tick();

        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule